// File: doc/BRIEF.md
# Tick Counter with Dual Alarms

This peripheral keeps time from a periodic tick strobe. An 8-bit fractional counter advances on every accepted tick. When it wraps from 0xFF to 0x00, it carries into a 32-bit long counter. Software reaches the block through a simple single-cycle register bus. Writes take effect at the clock edge that carries them. Read data is registered, so it appears on the cycle after the read strobe.

Two alarms can raise the interrupt:
- A long-interval alarm fires when the low 20 bits of the long counter become equal to a programmed value.
- A short-interval alarm is a reloading down-counter that fires every N ticks.

A control register holds:
- the timer enable, which is protected;
- the interrupt enables;
- the status flags;
- a write-enable guard bit;
- a busy/ready handshake.

After reset, and after every control write, busy stays high for a fixed number of cycles. New timer-enable and alarm-enable values are held back until busy falls. One interrupt output combines every flag with its enable.

Top module: `tick_alarm_timer`

## Requirements
- R1: After reset, the control register (address 0x10) reads 0x00000008 with busy (bit 3) set. The counters at 0x00 and 0x04 read 0, and the interrupt output is low.
- R2: A control write holds busy high for BUSY_CYC cycles (default 3). New values of timer enable (bit 0), long alarm enable (bit 1) and short alarm enable (bit 2) take effect, and read back, on the cycle busy falls.
- R3: A control write changes timer enable only if the stored write-enable bit (bit 15) is already 1 and busy is 0. Otherwise the written bit 0 is ignored.
- R4: While the active timer enable is 1, each cycle with the tick input high advances the fractional counter (0x04) by one. While it is 0, ticks change neither counter.
- R5: A tick that wraps the fractional counter from 0xFF to 0x00 increments the long counter (0x00) in the same cycle.
- R6: Ready (bit 4) is cleared in the cycle of each count update and set in the following cycle. A control write with bit 4 = 0 clears it, and a write of 1 does not set it.
- R7: The long alarm flag (bit 6) is raised when an update makes bits [19:0] of the long counter equal the 20-bit alarm register (0x08). It is cleared by a write to 0x08, or by a control write with bit 1 = 0.
- R8: A write to the reload register (0x0C) loads the short-alarm down-counter. The short flag (bit 7) is raised on the tick where the count is used up, which is every reload-value ticks. It is cleared by a write to 0x0C, or by a control write with bit 2 = 0.
- R9: A reload value of 0 never raises the short alarm flag.
- R10: The interrupt output is the OR of three terms: long flag AND active long enable, short flag AND active short enable, and ready AND ready-interrupt enable (bit 5). The ready-interrupt enable takes effect at once.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_i | input | 1 | Tick strobe, one count per high cycle |
| bus_sel_i | input | 1 | Register access strobe |
| bus_wr_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address of the register |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, registered, valid the cycle after a read |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check the following on every cycle:
- the carry from the fractional counter into the long counter;
- that the counters hold on cycles with no accepted tick;
- that the active enables move only on the cycle busy falls;
- that ready is low after every update and high one cycle after the last one;
- that the short flag cannot rise without a non-zero reload;
- that the interrupt stays low while no flag or ready is set.

Only the bench scenarios can show the following:
- that the write-enable gate ignores timer-enable writes that are unguarded or sent while busy;
- the exact length of the busy window as seen through reads;
- the alarm match points and the short alarm's period;
- the clearing of each flag by the two software paths.

// File: rtl/tat_pkg.sv
package tat_pkg;
   // register byte addresses
   localparam int A_LONG = 'h00;
   localparam int A_FRAC = 'h04;
   localparam int A_LALM = 'h08;
   localparam int A_SRLD = 'h0C;
   localparam int A_CTRL = 'h10;
   // control register bit positions
   localparam int B_EN   = 0;
   localparam int B_LIE  = 1;
   localparam int B_SIE  = 2;
   localparam int B_BUSY = 3;
   localparam int B_RDY  = 4;
   localparam int B_RDYE = 5;
   localparam int B_LFLG = 6;
   localparam int B_SFLG = 7;
   localparam int B_WE   = 15;
endpackage

// File: rtl/tat_count.sv
module tat_count #(
   parameter int FRAC_W = 8,
   parameter int LONG_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              step_i,
   output logic [FRAC_W-1:0] frac_o,
   output logic [LONG_W-1:0] long_o,
   output logic              wrap_o
);
   generate
      if (FRAC_W < 1 || LONG_W < 1) begin : g_bad
         $error("tat_count: widths must be positive");
      end
   endgenerate

   assign wrap_o = step_i && (frac_o == {FRAC_W{1'b1}});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         frac_o <= '0;
         long_o <= '0;
      end else if (step_i) begin
         frac_o <= frac_o + 1'b1;
         if (wrap_o) long_o <= long_o + 1'b1;
      end
   end

   assert_carry_R5: assert property (@(posedge clk) disable iff (!rst_n)
      wrap_o |=> (frac_o == '0) && (long_o == $past(long_o) + 1'b1));
   assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      !step_i |=> $stable(frac_o) && $stable(long_o));
endmodule

// File: rtl/tat_short.sv
module tat_short #(
   parameter int RLD_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             step_i,
   input  logic             load_i,
   input  logic [RLD_W-1:0] load_val_i,
   output logic [RLD_W-1:0] rld_o,
   output logic             roll_o
);
   generate
      if (RLD_W < 2) begin : g_bad
         $error("tat_short: RLD_W must be at least 2");
      end
   endgenerate

   logic [RLD_W-1:0] cnt;

   assign roll_o = step_i && (rld_o != '0) && (cnt < RLD_W'(2));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rld_o <= '0;
         cnt   <= '0;
      end else if (load_i) begin
         rld_o <= load_val_i;
         cnt   <= load_val_i;
      end else if (step_i && (rld_o != '0)) begin
         cnt <= (cnt < RLD_W'(2)) ? rld_o : cnt - 1'b1;
      end
   end

   assert_count_bound_R8: assert property (@(posedge clk) disable iff (!rst_n)
      cnt <= rld_o);
endmodule

// File: rtl/tat_ctrl.sv
module tat_ctrl #(
   parameter int BUSY_CYC = 3
) (
   input  logic clk,
   input  logic rst_n,
   input  logic wr_i,
   input  logic en_w,
   input  logic lie_w,
   input  logic sie_w,
   input  logic rdye_w,
   input  logic we_w,
   output logic busy_o,
   output logic en_o,
   output logic lie_o,
   output logic sie_o,
   output logic rdye_o,
   output logic we_o
);
   localparam int CNT_W = $clog2(BUSY_CYC + 1);

   generate
      if (BUSY_CYC < 1) begin : g_bad
         $error("tat_ctrl: BUSY_CYC must be at least 1");
      end
   endgenerate

   logic [CNT_W-1:0] bcnt;
   logic en_p, lie_p, sie_p;

   assign busy_o = (bcnt != '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bcnt   <= CNT_W'(BUSY_CYC);
         en_p   <= 1'b0;
         lie_p  <= 1'b0;
         sie_p  <= 1'b0;
         en_o   <= 1'b0;
         lie_o  <= 1'b0;
         sie_o  <= 1'b0;
         rdye_o <= 1'b0;
         we_o   <= 1'b0;
      end else if (wr_i) begin
         bcnt   <= CNT_W'(BUSY_CYC);
         we_o   <= we_w;
         rdye_o <= rdye_w;
         lie_p  <= lie_w;
         sie_p  <= sie_w;
         if (we_o && !busy_o) en_p <= en_w;
      end else if (busy_o) begin
         bcnt <= bcnt - 1'b1;
         if (bcnt == CNT_W'(1)) begin
            en_o  <= en_p;
            lie_o <= lie_p;
            sie_o <= sie_p;
         end
      end
   end

   assert_en_on_busy_fall_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ({en_o, lie_o, sie_o} != $past({en_o, lie_o, sie_o})) |-> ($past(busy_o) && !busy_o));
endmodule

// File: rtl/tick_alarm_timer.sv
module tick_alarm_timer
   import tat_pkg::*;
#(
   parameter int DATA_W   = 32,
   parameter int ADDR_W   = 5,
   parameter int FRAC_W   = 8,
   parameter int LONG_W   = 32,
   parameter int LALM_W   = 20,
   parameter int RLD_W    = 32,
   parameter int BUSY_CYC = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              bus_sel_i,
   input  logic              bus_wr_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [DATA_W-1:0] bus_wdata_i,
   output logic [DATA_W-1:0] bus_rdata_o,
   output logic              irq_o
);
   generate
      if (DATA_W < 16 || LONG_W > DATA_W || RLD_W > DATA_W || FRAC_W > DATA_W)
      begin : g_bad_w
         $error("tick_alarm_timer: register widths exceed data bus");
      end
      if (LALM_W > LONG_W || LALM_W < 1) begin : g_bad_a
         $error("tick_alarm_timer: LALM_W must be 1..LONG_W");
      end
      if (ADDR_W < 5) begin : g_bad_addr
         $error("tick_alarm_timer: ADDR_W too small for the map");
      end
   endgenerate

   logic wr, rd, wr_ctrl, wr_lalm, wr_srld;
   assign wr      = bus_sel_i && bus_wr_i;
   assign rd      = bus_sel_i && !bus_wr_i;
   assign wr_ctrl = wr && (bus_addr_i == ADDR_W'(A_CTRL));
   assign wr_lalm = wr && (bus_addr_i == ADDR_W'(A_LALM));
   assign wr_srld = wr && (bus_addr_i == ADDR_W'(A_SRLD));

   logic busy, en_a, lie_a, sie_a, rdye, we;

   tat_ctrl #(.BUSY_CYC(BUSY_CYC)) u_ctrl (
      .clk    (clk),
      .rst_n  (rst_n),
      .wr_i   (wr_ctrl),
      .en_w   (bus_wdata_i[B_EN]),
      .lie_w  (bus_wdata_i[B_LIE]),
      .sie_w  (bus_wdata_i[B_SIE]),
      .rdye_w (bus_wdata_i[B_RDYE]),
      .we_w   (bus_wdata_i[B_WE]),
      .busy_o (busy),
      .en_o   (en_a),
      .lie_o  (lie_a),
      .sie_o  (sie_a),
      .rdye_o (rdye),
      .we_o   (we)
   );

   logic step;
   assign step = tick_i && en_a;

   logic [FRAC_W-1:0] frac;
   logic [LONG_W-1:0] lng;
   logic              wrap;

   tat_count #(.FRAC_W(FRAC_W), .LONG_W(LONG_W)) u_count (
      .clk    (clk),
      .rst_n  (rst_n),
      .step_i (step),
      .frac_o (frac),
      .long_o (lng),
      .wrap_o (wrap)
   );

   logic [RLD_W-1:0] s_rld;
   logic             s_roll;

   tat_short #(.RLD_W(RLD_W)) u_short (
      .clk        (clk),
      .rst_n      (rst_n),
      .step_i     (step),
      .load_i     (wr_srld),
      .load_val_i (bus_wdata_i[RLD_W-1:0]),
      .rld_o      (s_rld),
      .roll_o     (s_roll)
   );

   // long alarm compare against the value the long counter is about to take
   logic [LALM_W-1:0] alarm;
   logic [LONG_W-1:0] long_nxt;
   logic              lcmp;
   assign long_nxt = lng + 1'b1;

   generate
      if (LALM_W < LONG_W) begin : g_cmp_slice
         assign lcmp = (long_nxt[LALM_W-1:0] == alarm);
      end else begin : g_cmp_full
         assign lcmp = (long_nxt == alarm);
      end
   endgenerate

   logic lflag, sflag, rdy, upd_d;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alarm <= '0;
         lflag <= 1'b0;
         sflag <= 1'b0;
         rdy   <= 1'b0;
         upd_d <= 1'b0;
      end else begin
         upd_d <= step;
         if (wr_lalm) alarm <= bus_wdata_i[LALM_W-1:0];

         if (wrap && lcmp) lflag <= 1'b1;
         else if (wr_lalm || (wr_ctrl && !bus_wdata_i[B_LIE])) lflag <= 1'b0;

         if (s_roll) sflag <= 1'b1;
         else if (wr_srld || (wr_ctrl && !bus_wdata_i[B_SIE])) sflag <= 1'b0;

         if (step) rdy <= 1'b0;
         else if (upd_d) rdy <= 1'b1;
         else if (wr_ctrl && !bus_wdata_i[B_RDY]) rdy <= 1'b0;
      end
   end

   logic [DATA_W-1:0] ctrl_rd;
   always_comb begin
      ctrl_rd         = '0;
      ctrl_rd[B_EN]   = en_a;
      ctrl_rd[B_LIE]  = lie_a;
      ctrl_rd[B_SIE]  = sie_a;
      ctrl_rd[B_BUSY] = busy;
      ctrl_rd[B_RDY]  = rdy;
      ctrl_rd[B_RDYE] = rdye;
      ctrl_rd[B_LFLG] = lflag;
      ctrl_rd[B_SFLG] = sflag;
      ctrl_rd[B_WE]   = we;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_rdata_o <= '0;
      end else if (rd) begin
         case (bus_addr_i)
            ADDR_W'(A_LONG): bus_rdata_o <= DATA_W'(lng);
            ADDR_W'(A_FRAC): bus_rdata_o <= DATA_W'(frac);
            ADDR_W'(A_LALM): bus_rdata_o <= DATA_W'(alarm);
            ADDR_W'(A_SRLD): bus_rdata_o <= DATA_W'(s_rld);
            ADDR_W'(A_CTRL): bus_rdata_o <= ctrl_rd;
            default:         bus_rdata_o <= '0;
         endcase
      end
   end

   assign irq_o = (lflag && lie_a) || (sflag && sie_a) || (rdy && rdye);

   assert_rdy_low_after_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      step |=> !rdy);
   assert_rdy_set_after_update_R6: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(step) && !step) |=> rdy);
   assert_sflag_needs_reload_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sflag) |-> ($past(s_rld) != '0));
   assert_irq_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (!lflag && !sflag && !rdy) |-> !irq_o);
endmodule

// File: tb/tick_alarm_timer_test.sv
module tick_alarm_timer_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic        bus_sel_i = 1'b0;
   logic        bus_wr_i = 1'b0;
   logic [4:0]  bus_addr_i = '0;
   logic [31:0] bus_wdata_i = '0;
   logic [31:0] bus_rdata_o;
   logic        irq_o;

   always #5 clk = ~clk;

   tick_alarm_timer uut (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
      .bus_sel_i(bus_sel_i), .bus_wr_i(bus_wr_i), .bus_addr_i(bus_addr_i),
      .bus_wdata_i(bus_wdata_i), .bus_rdata_o(bus_rdata_o), .irq_o(irq_o)
   );

   typedef struct {
      logic [31:0] mask;
      logic [31:0] exp;
      string       tag;
   } exp_t;

   exp_t q[$];
   int total = 0;
   int bad = 0;
   bit done = 0;

   // monitor: registered read data is compared just after the capturing edge
   always @(posedge clk) begin
      if (bus_sel_i && !bus_wr_i) begin
         #2;
         if (q.size() == 0) begin
            total++; bad++;
            $display("FAIL scoreboard: read with no expected item");
         end else begin
            exp_t e;
            e = q.pop_front();
            total++;
            if ((bus_rdata_o & e.mask) !== (e.exp & e.mask)) begin
               bad++;
               $display("FAIL %s: actual=%h expected=%h mask=%h",
                        e.tag, bus_rdata_o & e.mask, e.exp & e.mask, e.mask);
            end
         end
      end
   end

   // all tasks are entered at a falling edge and leave at a falling edge
   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_sel_i = 1; bus_wr_i = 1; bus_addr_i = a; bus_wdata_i = d;
      @(negedge clk);
      bus_sel_i = 0; bus_wr_i = 0;
   endtask

   task automatic rd(input logic [4:0] a, input logic [31:0] m,
                     input logic [31:0] x, input string tag);
      exp_t e;
      e.mask = m; e.exp = x; e.tag = tag;
      q.push_back(e);
      bus_sel_i = 1; bus_wr_i = 0; bus_addr_i = a;
      @(negedge clk);
      bus_sel_i = 0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic ticks(input int n);
      tick_i = 1;
      repeat (n) @(negedge clk);
      tick_i = 0;
   endtask

   task automatic chk_irq(input logic x, input string tag);
      total++;
      if (irq_o !== x) begin
         bad++;
         $display("FAIL %s: irq actual=%b expected=%b", tag, irq_o, x);
      end
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1;
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      total++; bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      finish_run();
   end

   int cnt;

   initial begin
      cnt = 0;
      repeat (3) @(negedge clk);
      rst_n = 1;
      chk_irq(0, "R1 reset irq");
      rd(5'h10, 32'hFFFF_FFFF, 32'h0000_0008, "R1 reset ctrl");
      rd(5'h04, 32'hFFFF_FFFF, 0, "R1 reset frac");
      rd(5'h00, 32'hFFFF_FFFF, 0, "R1 reset long");
      idle(6);

      // R3: enable write without the guard bit is ignored
      wr(5'h10, 32'h0000_0001);
      idle(5);
      rd(5'h10, 32'hFFFF_FFFF, 32'h0, "R3 unguarded enable ignored");
      ticks(5);
      idle(2);
      rd(5'h04, 32'hFFFF_FFFF, 0, "R4 no count while disabled");

      // R3: guard set, then enable write while busy is ignored
      wr(5'h10, 32'h0000_8000);
      wr(5'h10, 32'h0000_8001);
      idle(5);
      rd(5'h10, 32'hFFFF_FFFF, 32'h0000_8000, "R3 enable write during busy ignored");

      // R2: busy window and deferred enable
      wr(5'h10, 32'h0000_8001);
      rd(5'h10, 32'hFFFF_FFFF, 32'h0000_8008, "R2 busy cycle 1");
      rd(5'h10, 32'hFFFF_FFFF, 32'h0000_8008, "R2 busy cycle 2");
      rd(5'h10, 32'hFFFF_FFFF, 32'h0000_8008, "R2 busy cycle 3");
      rd(5'h10, 32'hFFFF_FFFF, 32'h0000_8001, "R2 enable applied at busy fall");

      // R6: ready clears on update, sets the cycle after
      ticks(1); cnt += 1;
      idle(2);
      ticks(1); cnt += 1;
      rd(5'h10, 32'h10, 32'h00, "R6 ready cleared on update");
      rd(5'h10, 32'h10, 32'h10, "R6 ready set after update");

      ticks(8); cnt += 8;
      idle(1);
      rd(5'h04, 32'hFFFF_FFFF, cnt % 256, "R4 fractional count");
      rd(5'h00, 32'hFFFF_FFFF, cnt / 256, "R4 long unchanged");

      wr(5'h10, 32'h0000_8001);
      idle(5);
      rd(5'h10, 32'h10, 32'h00, "R6 software clear of ready");

      // R5: carry
      ticks(246); cnt += 246;
      idle(1);
      rd(5'h04, 32'hFFFF_FFFF, 0, "R5 fractional wrapped");
      rd(5'h00, 32'hFFFF_FFFF, 1, "R5 long incremented");

      // R7: long alarm at long == 2
      wr(5'h08, 32'd2);
      ticks(255); cnt += 255;
      idle(1);
      rd(5'h10, 32'h40, 32'h00, "R7 no long flag before match");
      ticks(1); cnt += 1;
      idle(1);
      rd(5'h10, 32'h40, 32'h40, "R7 long flag at match");
      rd(5'h00, 32'hFFFF_FFFF, 2, "R5 long second carry");
      chk_irq(0, "R10 long flag masked");
      wr(5'h10, 32'h0000_8003);
      chk_irq(0, "R2 long enable deferred");
      idle(4);
      chk_irq(1, "R10 long alarm interrupt");
      wr(5'h08, 32'd5);
      chk_irq(0, "R7 alarm write clears flag");
      rd(5'h10, 32'h40, 32'h00, "R7 long flag cleared");

      // R8: short alarm every 5 ticks
      wr(5'h0C, 32'd5);
      ticks(4); cnt += 4;
      idle(1);
      rd(5'h10, 32'h80, 32'h00, "R8 no short flag after 4 ticks");
      ticks(1); cnt += 1;
      idle(1);
      rd(5'h10, 32'h80, 32'h80, "R8 short flag after 5 ticks");
      chk_irq(0, "R10 short flag masked");
      wr(5'h10, 32'h0000_8007);
      idle(4);
      chk_irq(1, "R10 short alarm interrupt");
      wr(5'h10, 32'h0000_8003);
      chk_irq(0, "R8 enable clear drops flag");
      rd(5'h10, 32'h80, 32'h00, "R8 short flag cleared");
      ticks(5); cnt += 5;
      idle(1);
      rd(5'h10, 32'h80, 32'h80, "R8 short flag repeats");

      // R9: reload of zero
      wr(5'h0C, 32'd0);
      ticks(20); cnt += 20;
      idle(1);
      rd(5'h10, 32'h80, 32'h00, "R9 zero reload stays quiet");

      // R10: ready interrupt enable acts at once
      wr(5'h10, 32'h0000_8023);
      idle(4);
      chk_irq(0, "R10 ready not set");
      ticks(1); cnt += 1;
      idle(1);
      chk_irq(1, "R10 ready interrupt");

      // R4: disabling stops counting
      wr(5'h10, 32'h0000_8000);
      idle(5);
      ticks(10);
      idle(1);
      rd(5'h04, 32'hFFFF_FFFF, cnt % 256, "R4 frozen fractional");
      rd(5'h00, 32'hFFFF_FFFF, cnt / 256, "R4 frozen long");
      idle(3);
      finish_run();
   end
endmodule